// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests from a set of sources for a small processor and decides which of them, if any, should interrupt the CPU. Every source owns a pending flag, an enable bit and a 3-bit priority. A flag is set by hardware when its source line rises and is cleared only by software, through a write-one-to-clear register. Among the pending, enabled sources with a non-zero priority, the controller picks a winner and presents its vector number and priority to the CPU.

The controller also holds the CPU's current priority level, 4 bits wide. Software can write the low three bits; the top bit is set only by hardware, on a trap. A request line to the CPU is raised only while the global enable is on and the winner's priority is strictly above the current level. When the CPU acknowledges, the old level is pushed onto a small stack and the level rises to the winner's priority. If nesting is disabled, the level rises to 7 instead, so no other user interrupt can pre-empt. A return strobe pops the saved level.

Top module: `vec_irq_ctrl`

## Requirements
- R1: A source's pending flag is set in the cycle after its input goes from 0 to 1. It stays set while the input stays high and until software clears it. A rising edge in the same cycle as a clear write leaves the flag set.
- R2: Word address 0 holds the pending flags, source n at bit n. Writing 1 to a bit clears that flag; writing 0 leaves it unchanged.
- R3: Word address 1 holds the enable bits, source n at bit n. A pending source whose enable bit is 0 never wins arbitration.
- R4: Source n's priority sits at word address 2 + n/4, bits [4*(n%4)+2 : 4*(n%4)]; the other bits read as 0. A source with priority 0 never wins.
- R5: The winner is the eligible source with the highest priority; on a tie the lowest index wins. The vector output is the winner's index plus 8, and the level output is its priority. Word address 8 reads vector in bits 7:0 and level in bits 11:8. It reads all zero when nothing is eligible.
- R6: The CPU request output is high exactly when the global enable is set, a winner exists and the winner's priority is strictly greater than the 4-bit current level.
- R7: Word address 6 holds the global enable in bit 0 and the nesting-disable bit in bit 1. With the global enable clear, no request is raised.
- R8: An acknowledge while the request is high pushes the current level on the stack. It then loads the winner's priority into the current level, or 7 if nesting is disabled. An acknowledge while the request is low has no effect.
- R9: A return strobe restores the most recently pushed level. A return with an empty stack leaves the level unchanged.
- R10: Word address 7 reads the current level in bits 3:0. A write changes only bits 2:0. A trap strobe pushes the current level and sets the level to 8. Trap takes precedence over acknowledge, which takes precedence over return, which takes precedence over a level write.
- R11: After reset all flags, enables, priorities, control bits and the current level are 0 and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Source request lines |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | 16 | Register write data |
| reg_we_i | input | 1 | Register write strobe |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i |
| ack_i | input | 1 | CPU acknowledge of the request |
| ret_i | input | 1 | Return from interrupt, restores saved level |
| trap_i | input | 1 | Trap taken, raises level to 8 |
| irq_req_o | output | 1 | Interrupt request to the CPU |
| irq_vec_o | output | 8 | Winning vector number |
| irq_lvl_o | output | 4 | Winning priority (new level) |
| cpu_lvl_o | output | 4 | Current CPU priority level |

## Verification
The bench targets priority ties, where a design that scanned the wrong way would report the higher-indexed source's vector. It checks a source held high across a clear, where a level-sensitive flag would immediately re-set, and a rising edge colliding with a clear of the same bit, which a clear-wins design would lose. It probes the strict comparison against the current level, including a 7-versus-7 case under nesting disable, where an off-by-one compare would raise a request. It also exercises a return on an empty stack, which a careless pointer would underflow into a garbage level, and a software write while the trap bit is set, which must not disturb bit 3.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int REG_W   = 16;
  localparam int PRIO_W  = 3;
  localparam int LVL_W   = 4;
  localparam int VEC_W   = 8;
  localparam int PRI_PER_WORD = REG_W / 4;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [LVL_W-1:0]  lvl_t;
  typedef logic [VEC_W-1:0]  vec_t;

  localparam lvl_t TRAP_LVL = lvl_t'(8);
  localparam lvl_t MAX_USER_LVL = lvl_t'(7);

  // Vector number of a source index.
  function automatic vec_t vec_of(input int idx, input int base);
    return vec_t'(idx + base);
  endfunction

  // Level loaded when a user interrupt is taken.
  function automatic lvl_t take_level(input prio_t p, input logic nest_off);
    return nest_off ? MAX_USER_LVL : lvl_t'(p);
  endfunction

  // A request may go out only when strictly above the current level.
  function automatic logic above_level(input prio_t p, input lvl_t cur);
    return lvl_t'(p) > cur;
  endfunction
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_ctrl_pkg::*;
#(
  parameter int NSRC = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSRC-1:0]        src_i,
  input  logic [NSRC-1:0]        flag_clr_i,
  input  logic [NSRC-1:0]        en_load_i,
  input  logic [NSRC-1:0]        en_val_i,
  input  logic [NSRC-1:0]        pri_load_i,
  input  logic [NSRC*PRIO_W-1:0] pri_val_i,
  output logic [NSRC-1:0]        flag_o,
  output logic [NSRC-1:0]        en_o,
  output logic [NSRC*PRIO_W-1:0] pri_o
);
  logic [NSRC-1:0] src_q;
  logic [NSRC-1:0] set_evt;

  for (genvar n = 0; n < NSRC; n++) begin : g_src
    assign set_evt[n] = src_i[n] & ~src_q[n];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q[n]  <= 1'b0;
        flag_o[n] <= 1'b0;
        en_o[n]   <= 1'b0;
        pri_o[n*PRIO_W +: PRIO_W] <= '0;
      end else begin
        src_q[n] <= src_i[n];
        if (set_evt[n])          flag_o[n] <= 1'b1;
        else if (flag_clr_i[n])  flag_o[n] <= 1'b0;
        if (en_load_i[n])        en_o[n] <= en_val_i[n];
        if (pri_load_i[n])       pri_o[n*PRIO_W +: PRIO_W] <= pri_val_i[n*PRIO_W +: PRIO_W];
      end
    end

    // R1: an edge always leaves the flag set, even against a clear.
    assert_edge_sets_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[n] |=> flag_o[n]);
    // R2: without an edge or a clear the flag holds.
    assert_flag_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_evt[n] && !flag_clr_i[n]) |=> $stable(flag_o[n]));
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_ctrl_pkg::*;
#(
  parameter int NSRC = 16,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSRC-1:0]        flag_i,
  input  logic [NSRC-1:0]        en_i,
  input  logic [NSRC*PRIO_W-1:0] pri_i,
  output logic                   win_valid_o,
  output logic [IDX_W-1:0]       win_idx_o,
  output prio_t                  win_pri_o
);
  logic [NSRC-1:0] eligible;

  for (genvar n = 0; n < NSRC; n++) begin : g_elig
    assign eligible[n] = flag_i[n] & en_i[n] & (pri_i[n*PRIO_W +: PRIO_W] != '0);
  end

  // Scan upward; only a strictly higher priority replaces the best,
  // so the lowest index keeps a tie.
  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    win_pri_o   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (eligible[i] && (pri_i[i*PRIO_W +: PRIO_W] > win_pri_o)) begin
        win_valid_o = 1'b1;
        win_idx_o   = IDX_W'(i);
        win_pri_o   = pri_i[i*PRIO_W +: PRIO_W];
      end
    end
  end

  // R3/R4: a reported winner is pending, enabled and non-zero.
  assert_winner_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |-> (eligible[win_idx_o] && win_pri_o != '0));
  // R5: any eligible source yields a winner.
  assert_winner_exists_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eligible != '0) |-> win_valid_o);
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  trap_i,
  input  logic  take_i,
  input  lvl_t  take_lvl_i,
  input  logic  ret_i,
  input  logic  sw_we_i,
  input  prio_t sw_val_i,
  output lvl_t  lvl_o
);
  lvl_t             stk [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic             push, pop, sw_wr;

  assign push  = trap_i | take_i;
  assign pop   = !push && ret_i && (cnt != '0);
  assign sw_wr = !push && !ret_i && sw_we_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_o <= '0;
      cnt   <= '0;
    end else begin
      if (push) begin
        if (cnt < CNT_W'(DEPTH)) begin
          stk[PTR_W'(cnt)] <= lvl_o;
          cnt <= cnt + 1'b1;
        end
        lvl_o <= trap_i ? TRAP_LVL : take_lvl_i;
      end else if (pop) begin
        lvl_o <= stk[PTR_W'(cnt - 1'b1)];
        cnt   <= cnt - 1'b1;
      end else if (sw_wr) begin
        lvl_o <= {lvl_o[LVL_W-1], sw_val_i};
      end
    end
  end

  // R10: a trap always lands at level 8.
  assert_trap_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> (lvl_o == TRAP_LVL));
  // R10: a software write never moves the hardware-only bit.
  assert_sw_keeps_top_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> (lvl_o[LVL_W-1] == $past(lvl_o[LVL_W-1])));
  // R9: a return on an empty stack leaves the level alone.
  assert_empty_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !push && cnt == '0) |=> $stable(lvl_o));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NSRC     = 16,
  parameter int VEC_BASE = 8,
  parameter int DEPTH    = 8,
  parameter int ADDR_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  input  logic              reg_we_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              ack_i,
  input  logic              ret_i,
  input  logic              trap_i,
  output logic              irq_req_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  output logic [LVL_W-1:0]  irq_lvl_o,
  output logic [LVL_W-1:0]  cpu_lvl_o
);
  localparam int IDX_W     = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int NFW       = (NSRC + REG_W - 1) / REG_W;
  localparam int NPW       = (NSRC + PRI_PER_WORD - 1) / PRI_PER_WORD;
  localparam int FLAG_BASE = 0;
  localparam int EN_BASE   = NFW;
  localparam int PRI_BASE  = 2 * NFW;
  localparam int CTRL_ADDR = PRI_BASE + NPW;
  localparam int LVL_ADDR  = CTRL_ADDR + 1;
  localparam int STAT_ADDR = CTRL_ADDR + 2;

  logic [NSRC-1:0]        flag, en;
  logic [NSRC*PRIO_W-1:0] pri;
  logic [NSRC-1:0]        flag_clr, en_load, en_val, pri_load;
  logic [NSRC*PRIO_W-1:0] pri_val;
  logic                   gie, nest_off;
  logic                   win_valid;
  logic [IDX_W-1:0]       win_idx;
  prio_t                  win_pri;
  logic                   take;
  logic                   ctrl_we, lvl_we;

  // Register write decode per source.
  for (genvar n = 0; n < NSRC; n++) begin : g_dec
    localparam int FW = n / REG_W;
    localparam int FB = n % REG_W;
    localparam int PW = n / PRI_PER_WORD;
    localparam int PB = 4 * (n % PRI_PER_WORD);
    assign flag_clr[n] = reg_we_i && (reg_addr_i == ADDR_W'(FLAG_BASE + FW)) && reg_wdata_i[FB];
    assign en_load[n]  = reg_we_i && (reg_addr_i == ADDR_W'(EN_BASE + FW));
    assign en_val[n]   = reg_wdata_i[FB];
    assign pri_load[n] = reg_we_i && (reg_addr_i == ADDR_W'(PRI_BASE + PW));
    assign pri_val[n*PRIO_W +: PRIO_W] = reg_wdata_i[PB +: PRIO_W];
  end

  assign ctrl_we = reg_we_i && (reg_addr_i == ADDR_W'(CTRL_ADDR));
  assign lvl_we  = reg_we_i && (reg_addr_i == ADDR_W'(LVL_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie      <= 1'b0;
      nest_off <= 1'b0;
    end else if (ctrl_we) begin
      gie      <= reg_wdata_i[0];
      nest_off <= reg_wdata_i[1];
    end
  end

  irq_src_bank #(.NSRC(NSRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .flag_clr_i(flag_clr), .en_load_i(en_load), .en_val_i(en_val),
    .pri_load_i(pri_load), .pri_val_i(pri_val),
    .flag_o(flag), .en_o(en), .pri_o(pri)
  );

  irq_arbiter #(.NSRC(NSRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .flag_i(flag), .en_i(en), .pri_i(pri),
    .win_valid_o(win_valid), .win_idx_o(win_idx), .win_pri_o(win_pri)
  );

  assign irq_vec_o = win_valid ? vec_of(int'(win_idx), VEC_BASE) : '0;
  assign irq_lvl_o = win_valid ? lvl_t'(win_pri) : '0;
  assign irq_req_o = gie && win_valid && above_level(win_pri, cpu_lvl_o);
  assign take      = ack_i && irq_req_o;

  irq_level_ctrl #(.DEPTH(DEPTH)) u_lvl (
    .clk(clk), .rst_n(rst_n), .trap_i(trap_i),
    .take_i(take), .take_lvl_i(take_level(win_pri, nest_off)),
    .ret_i(ret_i), .sw_we_i(lvl_we), .sw_val_i(reg_wdata_i[PRIO_W-1:0]),
    .lvl_o(cpu_lvl_o)
  );

  // Register read mux.
  always_comb begin
    reg_rdata_o = '0;
    for (int n = 0; n < NSRC; n++) begin
      if (reg_addr_i == ADDR_W'(FLAG_BASE + n / REG_W))
        reg_rdata_o[n % REG_W] = flag[n];
      if (reg_addr_i == ADDR_W'(EN_BASE + n / REG_W))
        reg_rdata_o[n % REG_W] = en[n];
      if (reg_addr_i == ADDR_W'(PRI_BASE + n / PRI_PER_WORD))
        reg_rdata_o[4 * (n % PRI_PER_WORD) +: PRIO_W] = pri[n*PRIO_W +: PRIO_W];
    end
    if (reg_addr_i == ADDR_W'(CTRL_ADDR)) reg_rdata_o[1:0] = {nest_off, gie};
    if (reg_addr_i == ADDR_W'(LVL_ADDR))  reg_rdata_o[LVL_W-1:0] = cpu_lvl_o;
    if (reg_addr_i == ADDR_W'(STAT_ADDR)) reg_rdata_o[VEC_W+LVL_W-1:0] = {irq_lvl_o, irq_vec_o};
  end

  // R6: a request is always strictly above the current level.
  assert_req_above_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (irq_lvl_o > cpu_lvl_o));
  // R7: global enable off blocks every request.
  assert_gie_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq_req_o);
  // R5: a requested vector carries the base offset.
  assert_vec_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (irq_vec_o >= VEC_W'(VEC_BASE)));
  // R8: taking an interrupt with nesting off lands at level 7.
  assert_nest_off_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && nest_off && !trap_i) |=> (cpu_lvl_o == MAX_USER_LVL));
  // R8: taking an interrupt with nesting on lands at the winner's level.
  assert_take_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !nest_off && !trap_i) |=> (cpu_lvl_o == $past(irq_lvl_o)));
endmodule

// File: tb/vec_irq_ctrl_bench.sv
module vec_irq_ctrl_bench;
  localparam int NSRC = 16;
  localparam int AW   = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   src = '0;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wdata = '0;
  logic          we = 1'b0, ack = 1'b0, ret = 1'b0, trap = 1'b0;
  logic [15:0]   rdata;
  logic          req;
  logic [7:0]    vec;
  logic [3:0]    lvl, cpu;

  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vec_irq_ctrl u_vec_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_we_i(we), .reg_rdata_o(rdata),
    .ack_i(ack), .ret_i(ret), .trap_i(trap),
    .irq_req_o(req), .irq_vec_o(vec), .irq_lvl_o(lvl), .cpu_lvl_o(cpu)
  );

  // ---------------- reference model ----------------
  int m_flag[NSRC], m_en[NSRC], m_pri[NSRC], m_prev[NSRC];
  int m_gie, m_nd, m_lvl;
  int m_stk[$];

  function automatic int m_win();
    int best = -1, bp = 0;
    for (int i = 0; i < NSRC; i++)
      if (m_flag[i] != 0 && m_en[i] != 0 && m_pri[i] > bp) begin best = i; bp = m_pri[i]; end
    return best;
  endfunction

  function automatic int m_req();
    int w = m_win();
    return (m_gie != 0 && w >= 0 && m_pri[w] > m_lvl) ? 1 : 0;
  endfunction

  function automatic int m_vec();
    int w = m_win();
    return (w >= 0) ? w + 8 : 0;
  endfunction

  function automatic int m_wlvl();
    int w = m_win();
    return (w >= 0) ? m_pri[w] : 0;
  endfunction

  function automatic int m_read(int a);
    int r = 0;
    if (a == 0) for (int i = 0; i < NSRC; i++) r += m_flag[i] << i;
    else if (a == 1) for (int i = 0; i < NSRC; i++) r += m_en[i] << i;
    else if (a >= 2 && a <= 5) for (int k = 0; k < 4; k++) r += m_pri[(a-2)*4 + k] << (4*k);
    else if (a == 6) r = m_gie + 2 * m_nd;
    else if (a == 7) r = m_lvl;
    else if (a == 8) r = m_vec() + (m_wlvl() << 8);
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) begin m_flag[i] = 0; m_en[i] = 0; m_pri[i] = 0; m_prev[i] = 0; end
      m_gie = 0; m_nd = 0; m_lvl = 0; m_stk.delete();
    end else begin
      int w, rq, nd_old;
      w = m_win(); rq = m_req(); nd_old = m_nd;
      if (trap) begin m_stk.push_back(m_lvl); m_lvl = 8; end
      else if (ack && rq != 0) begin m_stk.push_back(m_lvl); m_lvl = (nd_old != 0) ? 7 : m_pri[w]; end
      else if (ret) begin if (m_stk.size() > 0) m_lvl = m_stk.pop_back(); end
      else if (we && addr == 7) m_lvl = (m_lvl & 8) | (int'(wdata) & 7);
      if (we) begin
        if (addr == 0) for (int i = 0; i < NSRC; i++) if (wdata[i]) m_flag[i] = 0;
        if (addr == 1) for (int i = 0; i < NSRC; i++) m_en[i] = int'(wdata[i]);
        if (addr >= 2 && addr <= 5) for (int k = 0; k < 4; k++) m_pri[(int'(addr)-2)*4 + k] = (int'(wdata) >> (4*k)) & 7;
        if (addr == 6) begin m_gie = int'(wdata[0]); m_nd = int'(wdata[1]); end
      end
      for (int i = 0; i < NSRC; i++) begin
        if (src[i] && m_prev[i] == 0) m_flag[i] = 1;
        m_prev[i] = int'(src[i]);
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare outputs every cycle, away from both edges.
  always @(posedge clk) begin
    #15;
    if (rst_n && !done) begin
      chk("R6 request", int'(req), m_req());
      chk("R5 vector", int'(vec), m_vec());
      chk("R5 level", int'(lvl), m_wlvl());
      chk("R8 R9 R10 cpu level", int'(cpu), m_lvl);
    end
  end

  task automatic rd(input int a, input string tag);
    @(negedge clk); addr = AW'(a); #3;
    chk(tag, int'(rdata), m_read(a));
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); we = 1'b1; addr = AW'(a); wdata = 16'(d);
    @(negedge clk); we = 1'b0;
  endtask

  task automatic pulse_src(input int n);
    @(negedge clk); src[n] = 1'b1;
    @(negedge clk); src[n] = 1'b0;
  endtask

  task automatic strobe(input int which);
    @(negedge clk);
    if (which == 0) ack = 1'b1; else if (which == 1) ret = 1'b1; else trap = 1'b1;
    @(negedge clk); ack = 1'b0; ret = 1'b0; trap = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state
    for (int a = 0; a <= 8; a++) rd(a, "R11 reset register");
    @(negedge clk); #7; chk("R11 no request after reset", int'(req), 0);

    // Configuration: R3 enables, R4 priorities, R7 control
    wr(1, 16'hFFFF); rd(1, "R3 enable word");
    wr(2, 16'h0553); rd(2, "R4 priority word 0");
    wr(3, 16'h1276); rd(3, "R4 priority word 1");
    wr(4, 16'hFFFF); rd(4, "R4 unused bits read zero");
    wr(4, 0);
    wr(6, 1); rd(6, "R7 control word");

    // R4: priority 0 source pends but never requests
    pulse_src(3); idle(1);
    rd(0, "R1 flag set by edge");
    rd(8, "R4 priority zero not eligible");

    // R5: single winner, then a tie with a lower index
    pulse_src(2); idle(1); rd(8, "R5 status single winner");
    pulse_src(1); idle(1); rd(8, "R5 tie lowest index wins");

    // R1: held-high source does not re-set after a clear
    @(negedge clk); src[0] = 1'b1;
    idle(2); wr(0, 16'h0001); idle(2);
    rd(0, "R1 held source stays cleared");
    @(negedge clk); src[0] = 1'b0;
    // R2: writing zeros clears nothing
    wr(0, 0); rd(0, "R2 zero write no effect");

    // R8: acknowledge, nested pre-emption; R9 returns
    strobe(0); rd(7, "R8 level after ack");
    strobe(0); rd(7, "R8 ack without request ignored");
    pulse_src(4); idle(1);
    strobe(0); rd(7, "R8 nested ack");
    strobe(1); rd(7, "R9 first return");
    strobe(1); rd(7, "R9 second return");
    strobe(1); rd(7, "R9 empty return unchanged");

    // R7: global enable off
    wr(6, 0); idle(1); @(negedge clk); #7; chk("R7 gie off no request", int'(req), 0);
    wr(6, 1);

    // R3: disable source 4, winner falls back
    wr(1, 16'hFFEF); idle(1); rd(8, "R3 disabled source excluded");

    // R8 nesting disabled: level 7, prio-7 source cannot request
    wr(6, 3); strobe(0); rd(7, "R8 nest off level 7");
    pulse_src(5); idle(1);
    @(negedge clk); #7; chk("R6 equal level no request", int'(req), 0);
    strobe(1); wr(6, 1);

    // R10: level register and trap
    strobe(1); strobe(1);
    wr(7, 16'h000F); rd(7, "R10 software cannot set top bit");
    strobe(2); rd(7, "R10 trap level");
    wr(7, 3); rd(7, "R10 write keeps top bit");
    strobe(1); rd(7, "R10 return from trap");
    wr(7, 0);

    // R1: edge and clear of the same bit in one cycle, set wins
    @(negedge clk); src[6] = 1'b1; we = 1'b1; addr = AW'(0); wdata = 16'h0040;
    @(negedge clk); we = 1'b0; src[6] = 1'b0;
    rd(0, "R1 set wins over clear");
    wr(0, 16'hFFFF); idle(2); rd(0, "R2 clear all flags");

    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule